// File: doc/BRIEF.md
# Load Mode Current Reference Generator

This block produces the current command for a linear electronic load. On each measurement strobe it snapshots the operating mode, the setpoints, the compliance limits and the calibrated terminal voltage. It then derives a mode target: a fixed current, a current that holds constant power, a current that emulates a resistance, or an absorbing clamp on the terminal voltage. That target is bounded by the smallest of the current ceiling, a power-derived current ceiling, an externally computed safe-operating-area clamp and an externally computed thermal limit.

The bounded value is not applied directly. The command walks toward it by at most a programmable step per update, in both directions. Each finished update is marked with a one-cycle valid strobe and a code that names the bound which won. The divisions needed for power and resistance behaviour share one sequential radix-2 divider, so an update takes a variable number of cycles depending on the mode. Strobes that arrive while an update is in progress are ignored.

Top module: `eload_iref_gen`

## Requirements
- R1: In constant-current mode (mode code 1) the target equals the current setpoint `iset`.
- R2: In constant-power mode (mode code 2) the target is floor(`pset` / `v_meas`). It is forced to zero when `v_meas` is zero or below `vmin`.
- R3: In constant-resistance mode (mode code 3) the target is floor(`v_meas` / `rset`). A zero `rset` gives the full-scale value (all ones).
- R4: In voltage-clamp mode (mode code 4) the target is full scale when `v_meas` is above `vset`, and zero otherwise. The slew ramp therefore integrates the clamp current.
- R5: The bound is the minimum of the target, `imax`, the power-limit current, `soa_lim` and `therm_lim`. A bound below the target clamps the command and never shuts it off.
- R6: The power-limit current is floor(`pmax` / `v_meas`). When `v_meas` is zero no division is done and it equals `imax`.
- R7: `lim_src` names the winning bound: 0 mode target, 1 current ceiling, 2 power limit, 3 thermal, 4 SOA. On equal values the higher code wins.
- R8: Each update moves `i_cmd` toward the bound by exactly `slew_step`, or lands on the bound when it is closer than that. This holds for rising and for falling moves.
- R9: Mode code 0, and any unused code (5 to 7), is off. The target is zero, `out_en` is low in that update, and the command ramps down at the slew rate.
- R10: Each accepted `smp_vld` yields exactly one one-cycle `cmd_vld` pulse with the new command. `i_cmd` holds its value between pulses, and strobes arriving during an update are ignored.
- R11: After reset `i_cmd` is 0, `cmd_vld` is 0, `out_en` is 0 and `lim_src` is 0.
- R12: A mode change starts the ramp from the present command. The command never steps by more than `slew_step` across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | New calibrated sample; starts an update when idle |
| mode | input | 3 | 0 off, 1 CC, 2 CP, 3 CR, 4 CV |
| v_meas | input | W | Calibrated terminal voltage |
| iset | input | W | Current setpoint |
| pset | input | W | Power setpoint |
| rset | input | W | Resistance setpoint |
| vset | input | W | Voltage-clamp setpoint |
| vmin | input | W | Minimum voltage guard for CP |
| imax | input | W | Current ceiling |
| pmax | input | W | Power ceiling |
| soa_lim | input | W | SOA clamp current |
| therm_lim | input | W | Thermal limit current |
| slew_step | input | W | Largest command change per update |
| i_cmd | output | W | Current command |
| cmd_vld | output | 1 | One-cycle strobe marking a new command |
| out_en | output | 1 | Low when the update was made in off mode |
| lim_src | output | 3 | Winning bound code (R7) |

## Verification
The slew limiter and the compliance clamp act in the same update. A limit can fall below the target while the ramp is still partway to it, or, after a mode change, the ramp can be heading one way while the new bound lies the other way. The bench provokes this by lowering the setpoint, switching from constant current to constant power mid-ramp, and going to off mode with a small step. It judges every update against a model that first takes the priority minimum and then applies the step limit. Ties between bounds, including the zero-voltage case where the power limit equals the current ceiling, are checked through the reported bound code.

// File: rtl/eload_ref_pkg.sv
package eload_ref_pkg;
    typedef enum logic [2:0] {
        MD_OFF = 3'd0,
        MD_CC  = 3'd1,
        MD_CP  = 3'd2,
        MD_CR  = 3'd3,
        MD_CV  = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        LS_MODE = 3'd0,
        LS_CUR  = 3'd1,
        LS_PWR  = 3'd2,
        LS_THM  = 3'd3,
        LS_SOA  = 3'd4
    } lsrc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDIV,
        ST_PWAIT,
        ST_MSEL,
        ST_MDIV,
        ST_MWAIT,
        ST_APPLY
    } st_e;
endpackage

// File: rtl/eload_div.sv
module eload_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  q;
        logic [W-1:0]  den;
        logic [W-1:0]  num;
    } div_t;

    div_t r_q, r_d;
    logic [W:0] trial;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem[W-1:0], r_q.q[W-1]};
        if (!r_q.busy && start) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.rem  = '0;
            r_d.q    = num;
            r_d.den  = den;
            r_d.num  = num;
        end else if (r_q.busy) begin
            r_d.q = {r_q.q[W-2:0], 1'b0};
            if (trial >= {1'b0, r_q.den}) begin
                r_d.rem  = trial - {1'b0, r_q.den};
                r_d.q[0] = 1'b1;
            end else begin
                r_d.rem = trial;
            end
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == CW'(W - 1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;
    assign quo  = r_q.q;

    logic [2*W-1:0] prod, wide_num, wide_den;
    always_comb begin
        wide_num = {{W{1'b0}}, r_q.num};
        wide_den = {{W{1'b0}}, r_q.den};
        prod     = {{W{1'b0}}, r_q.q} * wide_den;
    end

    a_r6_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && r_q.den != '0) |-> (prod <= wide_num && (wide_num - prod) < wide_den));

    a_r3_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && r_q.den == '0) |-> (r_q.q == '1));
endmodule

// File: rtl/eload_lim_arb.sv
module eload_lim_arb
    import eload_ref_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] tgt,
    input  logic [W-1:0] imax,
    input  logic [W-1:0] plim,
    input  logic [W-1:0] thm,
    input  logic [W-1:0] soa,
    output logic [W-1:0] bound,
    output lsrc_e        src
);
    always_comb begin
        bound = tgt;
        src   = LS_MODE;
        if (imax <= bound) begin bound = imax; src = LS_CUR; end
        if (plim <= bound) begin bound = plim; src = LS_PWR; end
        if (thm  <= bound) begin bound = thm;  src = LS_THM; end
        if (soa  <= bound) begin bound = soa;  src = LS_SOA; end
    end

    always_comb begin
        a_r5_min_bound: assert (bound <= tgt && bound <= imax && bound <= plim
                                && bound <= thm && bound <= soa);
        a_r7_mode_wins_strict: assert (src != LS_MODE || (tgt < imax && tgt < plim
                                && tgt < thm && tgt < soa));
    end
endmodule

// File: rtl/eload_slew.sv
module eload_slew #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] bound,
    input  logic [W-1:0] step,
    output logic [W-1:0] nxt
);
    logic [W-1:0] diff;

    always_comb begin
        if (bound >= cur) begin
            diff = bound - cur;
            nxt  = (diff > step) ? cur + step : bound;
        end else begin
            diff = cur - bound;
            nxt  = (diff > step) ? cur - step : bound;
        end
    end

    always_comb begin
        a_r8_between: assert ((nxt >= cur && nxt <= bound) || (nxt <= cur && nxt >= bound));
    end
endmodule

// File: rtl/eload_iref_gen.sv
module eload_iref_gen
    import eload_ref_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [2:0]   mode,
    input  logic [W-1:0] v_meas,
    input  logic [W-1:0] iset,
    input  logic [W-1:0] pset,
    input  logic [W-1:0] rset,
    input  logic [W-1:0] vset,
    input  logic [W-1:0] vmin,
    input  logic [W-1:0] imax,
    input  logic [W-1:0] pmax,
    input  logic [W-1:0] soa_lim,
    input  logic [W-1:0] therm_lim,
    input  logic [W-1:0] slew_step,
    output logic [W-1:0] i_cmd,
    output logic         cmd_vld,
    output logic         out_en,
    output logic [2:0]   lim_src
);
    typedef struct packed {
        st_e          state;
        mode_e        md;
        logic [W-1:0] v;
        logic [W-1:0] iset;
        logic [W-1:0] pset;
        logic [W-1:0] rset;
        logic [W-1:0] vset;
        logic [W-1:0] vmin;
        logic [W-1:0] imax;
        logic [W-1:0] pmax;
        logic [W-1:0] soa;
        logic [W-1:0] thm;
        logic [W-1:0] step;
        logic [W-1:0] plim;
        logic [W-1:0] tgt;
        logic [W-1:0] cmd;
        lsrc_e        src;
        logic         en;
        logic         vld;
    } core_t;

    core_t        r_q, r_d;
    logic         div_start, div_done;
    logic [W-1:0] div_num, div_den, div_quo;
    logic [W-1:0] arb_bound, slew_nxt;
    lsrc_e        arb_src;
    mode_e        md_in;

    always_comb begin
        case (mode)
            3'd1:    md_in = MD_CC;
            3'd2:    md_in = MD_CP;
            3'd3:    md_in = MD_CR;
            3'd4:    md_in = MD_CV;
            default: md_in = MD_OFF;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        case (r_q.state)
            ST_IDLE: if (smp_vld) begin
                r_d.md    = md_in;
                r_d.v     = v_meas;
                r_d.iset  = iset;
                r_d.pset  = pset;
                r_d.rset  = rset;
                r_d.vset  = vset;
                r_d.vmin  = vmin;
                r_d.imax  = imax;
                r_d.pmax  = pmax;
                r_d.soa   = soa_lim;
                r_d.thm   = therm_lim;
                r_d.step  = slew_step;
                r_d.plim  = imax;
                r_d.state = (v_meas == '0) ? ST_MSEL : ST_PDIV;
            end
            ST_PDIV: begin
                div_start = 1'b1;
                div_num   = r_q.pmax;
                div_den   = r_q.v;
                r_d.state = ST_PWAIT;
            end
            ST_PWAIT: if (div_done) begin
                r_d.plim  = div_quo;
                r_d.state = ST_MSEL;
            end
            ST_MSEL: begin
                r_d.state = ST_APPLY;
                r_d.tgt   = '0;
                case (r_q.md)
                    MD_CC: r_d.tgt = r_q.iset;
                    MD_CP: if (r_q.v != '0 && r_q.v >= r_q.vmin) r_d.state = ST_MDIV;
                    MD_CR: r_d.state = ST_MDIV;
                    MD_CV: r_d.tgt = (r_q.v > r_q.vset) ? '1 : '0;
                    default: r_d.tgt = '0;
                endcase
            end
            ST_MDIV: begin
                div_start = 1'b1;
                div_num   = (r_q.md == MD_CP) ? r_q.pset : r_q.v;
                div_den   = (r_q.md == MD_CP) ? r_q.v : r_q.rset;
                r_d.state = ST_MWAIT;
            end
            ST_MWAIT: if (div_done) begin
                r_d.tgt   = div_quo;
                r_d.state = ST_APPLY;
            end
            ST_APPLY: begin
                r_d.cmd   = slew_nxt;
                r_d.src   = arb_src;
                r_d.en    = (r_q.md != MD_OFF);
                r_d.vld   = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    eload_div #(.W(W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
    );

    eload_lim_arb #(.W(W)) arb_i (
        .tgt(r_q.tgt), .imax(r_q.imax), .plim(r_q.plim), .thm(r_q.thm),
        .soa(r_q.soa), .bound(arb_bound), .src(arb_src)
    );

    eload_slew #(.W(W)) slew_i (
        .cur(r_q.cmd), .bound(arb_bound), .step(r_q.step), .nxt(slew_nxt)
    );

    assign i_cmd   = r_q.cmd;
    assign cmd_vld = r_q.vld;
    assign out_en  = r_q.en;
    assign lim_src = r_q.src;

    a_r8_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |-> (((r_q.cmd >= $past(r_q.cmd)) ? (r_q.cmd - $past(r_q.cmd))
                                                   : ($past(r_q.cmd) - r_q.cmd)) <= r_q.step));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.vld |-> $stable(r_q.cmd));

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |=> !r_q.vld);

    a_r9_off_down: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && !r_q.en) |-> (r_q.cmd <= $past(r_q.cmd)));

    a_r2_vmin_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_APPLY && r_q.md == MD_CP && r_q.v < r_q.vmin) |-> (r_q.tgt == '0));
endmodule

// File: tb/eload_iref_gen_tb_top.sv
module eload_iref_gen_tb_top;
    localparam int W = 16;
    localparam logic [W-1:0] FS = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [W-1:0] v_meas = '0, iset = '0, pset = '0, rset = '0, vset = '0, vmin = '0;
    logic [W-1:0] imax = FS, pmax = FS, soa_lim = FS, therm_lim = FS, slew_step = FS;
    logic [W-1:0] i_cmd;
    logic cmd_vld, out_en;
    logic [2:0] lim_src;

    always #5 clk = ~clk;

    eload_iref_gen #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mode(mode), .v_meas(v_meas),
        .iset(iset), .pset(pset), .rset(rset), .vset(vset), .vmin(vmin), .imax(imax),
        .pmax(pmax), .soa_lim(soa_lim), .therm_lim(therm_lim), .slew_step(slew_step),
        .i_cmd(i_cmd), .cmd_vld(cmd_vld), .out_en(out_en), .lim_src(lim_src)
    );

    typedef struct {
        logic [W-1:0] cmd;
        logic [2:0]   src;
        logic         en;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] exp_cmd = '0;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Expected value from the requirements, computed for the present inputs
    task automatic push_model(input string tag);
        logic [W-1:0] plim, tgt, bnd, d;
        logic [2:0]   src;
        exp_t         e;
        plim = (v_meas == 0) ? imax : pmax / v_meas;
        case (mode)
            3'd1: tgt = iset;
            3'd2: tgt = (v_meas == 0 || v_meas < vmin) ? '0 : pset / v_meas;
            3'd3: tgt = (rset == 0) ? FS : v_meas / rset;
            3'd4: tgt = (v_meas > vset) ? FS : '0;
            default: tgt = '0;
        endcase
        bnd = tgt; src = 3'd0;
        if (imax <= bnd)      begin bnd = imax;      src = 3'd1; end
        if (plim <= bnd)      begin bnd = plim;      src = 3'd2; end
        if (therm_lim <= bnd) begin bnd = therm_lim; src = 3'd3; end
        if (soa_lim <= bnd)   begin bnd = soa_lim;   src = 3'd4; end
        if (bnd >= exp_cmd) begin
            d = bnd - exp_cmd;
            exp_cmd = (d > slew_step) ? exp_cmd + slew_step : bnd;
        end else begin
            d = exp_cmd - bnd;
            exp_cmd = (d > slew_step) ? exp_cmd - slew_step : bnd;
        end
        e.cmd = exp_cmd;
        e.src = src;
        e.en  = (mode >= 3'd1 && mode <= 3'd4);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic sample(input string tag);
        push_model(tag);
        @(negedge clk) smp_vld = 1'b1;
        @(negedge clk) smp_vld = 1'b0;
        // extra strobe while busy must be ignored (R10)
        @(negedge clk) smp_vld = 1'b1;
        @(negedge clk) smp_vld = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(i_cmd == exp_cmd && !cmd_vld, "R10 hold between updates", int'(i_cmd), int'(exp_cmd));
    endtask

    // Monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && cmd_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(i_cmd == e.cmd, {e.tag, " i_cmd"}, int'(i_cmd), int'(e.cmd));
                chk(lim_src == e.src, {e.tag, " lim_src R7"}, int'(lim_src), int'(e.src));
                chk(out_en == e.en, {e.tag, " out_en"}, int'(out_en), int'(e.en));
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(i_cmd == 0, "R11 reset i_cmd", int'(i_cmd), 0);
        chk(cmd_vld == 0, "R11 reset cmd_vld", int'(cmd_vld), 0);
        chk(out_en == 0, "R11 reset out_en", int'(out_en), 0);
        chk(lim_src == 0, "R11 reset lim_src", int'(lim_src), 0);

        v_meas = 10;
        mode = 3'd1; iset = 100;                 sample("R1 CC setpoint");
        mode = 3'd2; pset = 1000;                sample("R2 CP at v=10");
        v_meas = 7;                              sample("R2 CP at v=7");
        vmin = 5; v_meas = 4;                    sample("R2 CP below vmin");
        vmin = 0; v_meas = 0;                    sample("R2 CP at zero volts");
        mode = 3'd3; v_meas = 200; rset = 8;     sample("R3 CR divide");
        imax = 500; rset = 0;                    sample("R3 CR zero resistance");
        mode = 3'd4; vset = 50; v_meas = 60; imax = 300; sample("R4 CV above clamp");
        v_meas = 40;                             sample("R4 CV below clamp");
        mode = 3'd1; imax = FS; v_meas = 10; iset = 400; therm_lim = 250;
                                                 sample("R5 thermal clamp");
        soa_lim = 250;                           sample("R7 SOA over thermal tie");
        soa_lim = FS; therm_lim = FS; pmax = 2000; sample("R6 power limit");
        imax = 200;                              sample("R7 power over current tie");
        pmax = FS; iset = 200;                   sample("R7 current over mode tie");
        v_meas = 0; iset = 1000; imax = 300; pmax = 10;
                                                 sample("R6 zero volts uses imax");
        imax = FS; pmax = FS; v_meas = 10; slew_step = 30; iset = 100;
        for (int k = 0; k < 8; k++)              sample("R8 falling ramp");
        iset = 170;
        for (int k = 0; k < 4; k++)              sample("R8 rising ramp");
        mode = 3'd2; pset = 500;
        for (int k = 0; k < 5; k++)              sample("R12 CC to CP change");
        mode = 3'd0;
        for (int k = 0; k < 3; k++)              sample("R9 off ramp down");
        mode = 3'd6;
        for (int k = 0; k < 2; k++)              sample("R9 unused code is off");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule